// File: doc/BRIEF.md
# Flash Memory Controller with Erase

This block is a register-mapped front end for a small on-chip NOR-style flash array and a separate array of user configuration words. One 32-bit bus port serves three windows, chosen by a select field. The control window holds a mode register, a ready status and the erase commands. The flash window gives word reads and bit-clearing writes. The user-config window gives plain word reads and writes.

A write to flash can only turn ones into zeros: the stored word becomes the old word ANDed with the written value. Erases return whole regions to all ones. Page and bulk erases are allowed only while the erase-enable mode bit is set. The bulk erase and the user-config erase also require a key value. Every erase completes in the cycle it is accepted, and a one-cycle busy strobe marks it. Each rejected access raises a one-cycle error pulse. Read data and all status outputs come out registered, one cycle after the request.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset the mode register reads 0, every user-config word reads 0xFFFFFFFF, and the error and busy outputs are low.
- R2: The mode register at control offset 0x00 keeps only bit 0 (write-enable) and bit 1 (erase-enable). The other written bits read back as zero.
- R3: The ready status at control offset 0x04 always reads 0x00000001.
- R4: A flash-window write with write-enable set stores the old word ANDed with the written data.
- R5: A flash-window write with write-enable clear leaves the word unchanged and pulses the error output.
- R6: A write to either page-erase command (control offsets 0x08 and 0x0C) with erase-enable set drops the in-page offset bits of the written byte address. It fills that page with ones, leaves every other page untouched, and pulses busy.
- R7: A page-erase address whose page would extend past the end of the flash is ignored: nothing changes, and neither error nor busy is raised.
- R8: A page-erase write with erase-enable clear erases nothing and pulses error. Error and busy are never high together.
- R9: A write of the erase key (default 1) to the bulk-erase command (offset 0x10) with erase-enable set fills all of flash and all of the user-config array with ones and pulses busy. The same write with erase-enable clear pulses error and changes nothing. Any other value is ignored silently.
- R10: A write of the erase key to the user-config erase command (offset 0x14) fills the user-config array with ones and pulses busy, whatever the mode register holds. Other values are ignored.
- R11: The user-config window stores and returns whole words unchanged.
- R12: A control read at any offset other than 0x00 and 0x04, a control write at any offset other than 0x00 and 0x08 to 0x14, and any access with select value 3 pulse error, change nothing, and read as 0.
- R13: A flash or user-config access at a byte address beyond the window size pulses error, writes nothing and reads as 0.
- R14: Every read request gives one cycle of read-valid with its data in the following cycle. A write never raises read-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | Window: 0 control, 1 flash, 2 user-config, 3 none |
| bus_addr | input | BUS_AW | Word-aligned byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| err_pulse | output | 1 | One-cycle pulse for a rejected access |
| busy | output | 1 | One-cycle strobe for an accepted erase |

## Verification
The assertions take for granted that every request carries a word-aligned address (the low two address bits are zero) and that the select and write lines are stable for the one cycle the request is held. The bench drives every access from a task that builds addresses as multiples of four and holds the request for exactly one clock. Random addresses run a short way past each window's end, so the out-of-range and past-the-end page cases come up without breaking alignment. Bulk erases are kept rare in the random mix, so that cleared bits build up between erases and the AND rule stays observable.

// File: rtl/nvm_pkg.sv
// Shared constants for the flash controller: window select codes,
// control register offsets and mode register bit positions.
package nvm_pkg;

    typedef enum logic [1:0] {
        WIN_CTL   = 2'd0,
        WIN_FLASH = 2'd1,
        WIN_UCFG  = 2'd2,
        WIN_NONE  = 2'd3
    } nvm_win_e;

    localparam int unsigned OFS_MODE     = 32'h00;
    localparam int unsigned OFS_READY    = 32'h04;
    localparam int unsigned OFS_PG_ERA_A = 32'h08;
    localparam int unsigned OFS_PG_ERA_B = 32'h0C;
    localparam int unsigned OFS_BULK_ERA = 32'h10;
    localparam int unsigned OFS_UCFG_ERA = 32'h14;

    localparam int unsigned MODE_WEN_BIT = 0;
    localparam int unsigned MODE_EEN_BIT = 1;
    localparam int unsigned MODE_BITS    = 2;

endpackage

// File: rtl/nvm_ctl_regs.sv
// Control window: holds the mode register and decodes the erase commands.
// Assumes the caller qualifies acc_valid with the control window select.
// Produces single-cycle command strobes, read data and an error flag,
// all combinational. Only the mode register is state.
module nvm_ctl_regs
    import nvm_pkg::*;
#(
    parameter int unsigned FLASH_BYTES = 2048,
    parameter int unsigned PAGE_BYTES  = 256,
    parameter int unsigned BUS_AW      = 16,
    parameter logic [31:0] ERASE_KEY   = 32'd1,
    localparam int unsigned PAGES      = FLASH_BYTES / PAGE_BYTES,
    localparam int unsigned PAGE_W     = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int unsigned PAGE_SHIFT = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [BUS_AW-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic              mode_wen,
    output logic              mode_een,
    output logic              page_era_go,
    output logic [PAGE_W-1:0] page_era_idx,
    output logic              bulk_era_go,
    output logic              ucfg_era_go,
    output logic [31:0]       ctl_rdata,
    output logic              ctl_err
);

    localparam logic [31:0] PAGE_MASK = ~(32'(PAGE_BYTES) - 32'd1);
    localparam logic [31:0] LAST_BASE = 32'(FLASH_BYTES - PAGE_BYTES);

    logic [MODE_BITS-1:0] mode_q;
    logic                 mode_wr;
    logic [31:0]          page_base;
    logic                 page_fits;
    logic                 key_hit;

    assign mode_wen     = mode_q[MODE_WEN_BIT];
    assign mode_een     = mode_q[MODE_EEN_BIT];
    assign page_base    = acc_wdata & PAGE_MASK;
    assign page_fits    = (page_base <= LAST_BASE);
    assign page_era_idx = page_base[PAGE_SHIFT +: PAGE_W];
    assign key_hit      = (acc_wdata == ERASE_KEY);

    // Mode register: only the defined enable bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= acc_wdata[MODE_BITS-1:0];
        end
    end

    // Offset decode: read mux, command strobes and permission checks.
    always_comb begin
        ctl_rdata   = '0;
        ctl_err     = 1'b0;
        mode_wr     = 1'b0;
        page_era_go = 1'b0;
        bulk_era_go = 1'b0;
        ucfg_era_go = 1'b0;
        if (acc_valid) begin
            if (!acc_we) begin
                if (acc_addr == BUS_AW'(OFS_MODE)) begin
                    ctl_rdata = {{(32-MODE_BITS){1'b0}}, mode_q};
                end else if (acc_addr == BUS_AW'(OFS_READY)) begin
                    ctl_rdata = 32'd1;
                end else begin
                    ctl_err = 1'b1;
                end
            end else begin
                if (acc_addr == BUS_AW'(OFS_MODE)) begin
                    mode_wr = 1'b1;
                end else if (acc_addr == BUS_AW'(OFS_PG_ERA_A) ||
                             acc_addr == BUS_AW'(OFS_PG_ERA_B)) begin
                    if (!mode_een) begin
                        ctl_err = 1'b1;
                    end else if (page_fits) begin
                        page_era_go = 1'b1;
                    end
                end else if (acc_addr == BUS_AW'(OFS_BULK_ERA)) begin
                    if (key_hit) begin
                        if (mode_een) begin
                            bulk_era_go = 1'b1;
                        end else begin
                            ctl_err = 1'b1;
                        end
                    end
                end else if (acc_addr == BUS_AW'(OFS_UCFG_ERA)) begin
                    ucfg_era_go = key_hit;
                end else begin
                    ctl_err = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/nvm_flash_array.sv
// Flash storage as one register per word. A write ANDs into the word.
// A page or bulk erase sets words to ones in one cycle. The content is
// non-volatile, so it has no reset; the user erases it before use.
// Assumes at most one of wr_en, page_era and bulk_era is high per cycle.
module nvm_flash_array #(
    parameter int unsigned FLASH_BYTES = 2048,
    parameter int unsigned PAGE_BYTES  = 256,
    localparam int unsigned WORDS      = FLASH_BYTES / 4,
    localparam int unsigned PAGE_WORDS = PAGE_BYTES / 4,
    localparam int unsigned PAGES      = FLASH_BYTES / PAGE_BYTES,
    localparam int unsigned IDX_W      = $clog2(WORDS),
    localparam int unsigned PAGE_W     = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              page_era,
    input  logic [PAGE_W-1:0] page_idx,
    input  logic              bulk_era,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       rd_data
);

    logic [31:0] words [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam int unsigned MY_PAGE = w / PAGE_WORDS;
        logic [31:0] word_q;
        logic        hit_era;

        assign hit_era  = bulk_era || (page_era && page_idx == PAGE_W'(MY_PAGE));
        assign words[w] = word_q;

        // One flash word: erase to ones, or clear bits on a write.
        always_ff @(posedge clk) begin
            if (hit_era) begin
                word_q <= '1;
            end else if (wr_en && wr_idx == IDX_W'(w)) begin
                word_q <= word_q & wr_data;
            end
        end
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/nvm_ucfg_array.sv
// User configuration words: plain read and write storage, set to ones
// by reset or by an erase strobe. Assumes wr_en and erase are never high
// together.
module nvm_ucfg_array #(
    parameter int unsigned UCFG_WORDS = 64,
    localparam int unsigned IDX_W     = $clog2(UCFG_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             erase,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);

    logic [31:0] words [UCFG_WORDS];

    for (genvar w = 0; w < UCFG_WORDS; w++) begin : g_word
        logic [31:0] word_q;

        assign words[w] = word_q;

        // One user word: ones on reset or erase, else take the write data.
        always_ff @(posedge clk) begin
            if (!rst_n || erase) begin
                word_q <= '1;
            end else if (wr_en && wr_idx == IDX_W'(w)) begin
                word_q <= wr_data;
            end
        end
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/nvm_ctrl.sv
// Top level of the flash controller. Splits the bus among the control,
// flash and user-config windows, applies the range and permission checks,
// and registers read data, read-valid, error and busy for one cycle.
// Assumes word-aligned addresses and one-cycle requests.
module nvm_ctrl
    import nvm_pkg::*;
#(
    parameter int unsigned FLASH_BYTES = 2048,
    parameter int unsigned PAGE_BYTES  = 256,
    parameter int unsigned UCFG_WORDS  = 64,
    parameter int unsigned BUS_AW      = 16,
    parameter logic [31:0] ERASE_KEY   = 32'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              err_pulse,
    output logic              busy
);

    localparam int unsigned FL_WORDS = FLASH_BYTES / 4;
    localparam int unsigned FL_IDX_W = $clog2(FL_WORDS);
    localparam int unsigned UC_IDX_W = $clog2(UCFG_WORDS);
    localparam int unsigned PAGES    = FLASH_BYTES / PAGE_BYTES;
    localparam int unsigned PAGE_W   = (PAGES > 1) ? $clog2(PAGES) : 1;
    localparam int unsigned UC_BYTES = UCFG_WORDS * 4;

    logic              sel_ctl, sel_fl, sel_uc, sel_none;
    logic              fl_in_rng, uc_in_rng;
    logic              mode_wen, mode_een;
    logic              page_era_go, bulk_era_go, ucfg_era_go;
    logic [PAGE_W-1:0] page_era_idx;
    logic [31:0]       ctl_rdata, fl_rdata, uc_rdata;
    logic              ctl_err;
    logic              fl_wr, uc_wr, fl_err, uc_err;
    logic [31:0]       rd_mux;
    logic              any_err;

    assign sel_ctl   = bus_valid && bus_sel == WIN_CTL;
    assign sel_fl    = bus_valid && bus_sel == WIN_FLASH;
    assign sel_uc    = bus_valid && bus_sel == WIN_UCFG;
    assign sel_none  = bus_valid && bus_sel == WIN_NONE;
    assign fl_in_rng = 32'(bus_addr) < 32'(FLASH_BYTES);
    assign uc_in_rng = 32'(bus_addr) < 32'(UC_BYTES);

    assign fl_wr  = sel_fl && bus_we && fl_in_rng && mode_wen;
    assign fl_err = sel_fl && (!fl_in_rng || (bus_we && !mode_wen));
    assign uc_wr  = sel_uc && bus_we && uc_in_rng;
    assign uc_err = sel_uc && !uc_in_rng;

    nvm_ctl_regs #(
        .FLASH_BYTES (FLASH_BYTES),
        .PAGE_BYTES  (PAGE_BYTES),
        .BUS_AW      (BUS_AW),
        .ERASE_KEY   (ERASE_KEY)
    ) ctl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (sel_ctl),
        .acc_we       (bus_we),
        .acc_addr     (bus_addr),
        .acc_wdata    (bus_wdata),
        .mode_wen     (mode_wen),
        .mode_een     (mode_een),
        .page_era_go  (page_era_go),
        .page_era_idx (page_era_idx),
        .bulk_era_go  (bulk_era_go),
        .ucfg_era_go  (ucfg_era_go),
        .ctl_rdata    (ctl_rdata),
        .ctl_err      (ctl_err)
    );

    nvm_flash_array #(
        .FLASH_BYTES (FLASH_BYTES),
        .PAGE_BYTES  (PAGE_BYTES)
    ) flash_i (
        .clk      (clk),
        .wr_en    (fl_wr),
        .wr_idx   (bus_addr[FL_IDX_W+1:2]),
        .wr_data  (bus_wdata),
        .page_era (page_era_go),
        .page_idx (page_era_idx),
        .bulk_era (bulk_era_go),
        .rd_idx   (bus_addr[FL_IDX_W+1:2]),
        .rd_data  (fl_rdata)
    );

    nvm_ucfg_array #(
        .UCFG_WORDS (UCFG_WORDS)
    ) ucfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (uc_wr),
        .wr_idx  (bus_addr[UC_IDX_W+1:2]),
        .wr_data (bus_wdata),
        .erase   (bulk_era_go || ucfg_era_go),
        .rd_idx  (bus_addr[UC_IDX_W+1:2]),
        .rd_data (uc_rdata)
    );

    assign any_err = ctl_err || fl_err || uc_err || sel_none;

    // Read source select; rejected reads return zero.
    always_comb begin
        rd_mux = '0;
        if (sel_ctl) begin
            rd_mux = ctl_rdata;
        end else if (sel_fl && fl_in_rng) begin
            rd_mux = fl_rdata;
        end else if (sel_uc && uc_in_rng) begin
            rd_mux = uc_rdata;
        end
    end

    // Output stage: registered read data and one-cycle status strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            err_pulse  <= 1'b0;
            busy       <= 1'b0;
        end else begin
            bus_rdata  <= (bus_valid && !bus_we) ? rd_mux : '0;
            bus_rvalid <= bus_valid && !bus_we;
            err_pulse  <= any_err;
            busy       <= page_era_go || bulk_era_go || ucfg_era_go;
        end
    end

endmodule

// File: rtl/nvm_ctrl_checker.sv
// Protocol and status properties for nvm_ctrl, bound to every instance.
// Assumes word-aligned bus addresses, which the first property states.
module nvm_ctrl_checker #(
    parameter int unsigned FLASH_BYTES = 2048,
    parameter int unsigned BUS_AW      = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [1:0]        bus_sel,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic              err_pulse,
    input logic              busy,
    input logic              mode_wen
);

    p_aligned_input: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_addr[1:0] == 2'b00);

    // R14: one read-valid per read request, none for anything else
    p_rvalid_on_read_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we) |=> bus_rvalid);
    p_no_rvalid_idle_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_we) |=> !bus_rvalid);

    // R2: mode register reads carry nothing above the enable bits
    p_mode_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && bus_sel == 2'd0 && bus_addr == '0)
        |=> (bus_rdata[31:2] == 30'd0 && !err_pulse));

    // R3: ready status reads as one
    p_ready_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && bus_sel == 2'd0 && bus_addr == BUS_AW'(4))
        |=> bus_rdata == 32'd1);

    // R6: busy only follows a control-window write
    p_busy_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $past(bus_valid && bus_we && bus_sel == 2'd0));

    // R8: a rejected access never erases
    p_err_busy_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_pulse && busy));

    // R5: a flash write without write-enable is flagged
    p_wen_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && bus_sel == 2'd1 &&
         32'(bus_addr) < 32'(FLASH_BYTES) && !mode_wen) |=> err_pulse);

endmodule

bind nvm_ctrl nvm_ctrl_checker #(
    .FLASH_BYTES (FLASH_BYTES),
    .BUS_AW      (BUS_AW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_we     (bus_we),
    .bus_sel    (bus_sel),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .err_pulse  (err_pulse),
    .busy       (busy),
    .mode_wen   (mode_wen)
);

// File: tb/nvm_ctrl_tb_top.sv
// Self-checking bench: directed corner cases, then seeded random accesses,
// each compared against a behavioural model kept in bench variables.
module nvm_ctrl_tb_top;

    localparam int unsigned FLASH_BYTES = 2048;
    localparam int unsigned PAGE_BYTES  = 256;
    localparam int unsigned UCFG_WORDS  = 64;
    localparam int unsigned BUS_AW      = 16;
    localparam logic [31:0] KEY         = 32'd1;
    localparam int unsigned FW          = FLASH_BYTES / 4;
    localparam int unsigned PW          = PAGE_BYTES / 4;

    localparam logic [1:0] S_CTL = 2'd0, S_FL = 2'd1, S_UC = 2'd2, S_NO = 2'd3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_valid, bus_we;
    logic [1:0]        bus_sel;
    logic [BUS_AW-1:0] bus_addr;
    logic [31:0]       bus_wdata, bus_rdata;
    logic              bus_rvalid, err_pulse, busy;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] fl_m [FW];
    logic [31:0] uc_m [UCFG_WORDS];
    logic [1:0]  mode_m;

    always #5 clk = ~clk;

    nvm_ctrl #(
        .FLASH_BYTES (FLASH_BYTES),
        .PAGE_BYTES  (PAGE_BYTES),
        .UCFG_WORDS  (UCFG_WORDS),
        .BUS_AW      (BUS_AW),
        .ERASE_KEY   (KEY)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_we     (bus_we),
        .bus_sel    (bus_sel),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .err_pulse  (err_pulse),
        .busy       (busy)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Model one access; returns expected read data, error and busy.
    function automatic void model(input logic [1:0] sel, input logic we,
                                  input logic [31:0] a, input logic [31:0] d,
                                  output logic [31:0] rd, output logic er,
                                  output logic bz);
        logic [31:0] base;
        rd = '0; er = 1'b0; bz = 1'b0;
        case (sel)
            S_CTL: begin
                if (!we) begin
                    if (a == 32'h0) rd = {30'd0, mode_m};
                    else if (a == 32'h4) rd = 32'd1;
                    else er = 1'b1;
                end else if (a == 32'h0) begin
                    mode_m = d[1:0];
                end else if (a == 32'h8 || a == 32'hC) begin
                    base = d & ~(PAGE_BYTES - 1);
                    if (!mode_m[1]) er = 1'b1;
                    else if (base <= FLASH_BYTES - PAGE_BYTES) begin
                        bz = 1'b1;
                        for (int i = 0; i < PW; i++) fl_m[base/4 + i] = '1;
                    end
                end else if (a == 32'h10) begin
                    if (d == KEY) begin
                        if (mode_m[1]) begin
                            bz = 1'b1;
                            for (int i = 0; i < FW; i++) fl_m[i] = '1;
                            for (int i = 0; i < UCFG_WORDS; i++) uc_m[i] = '1;
                        end else er = 1'b1;
                    end
                end else if (a == 32'h14) begin
                    if (d == KEY) begin
                        bz = 1'b1;
                        for (int i = 0; i < UCFG_WORDS; i++) uc_m[i] = '1;
                    end
                end else er = 1'b1;
            end
            S_FL: begin
                if (a >= FLASH_BYTES) er = 1'b1;
                else if (!we) rd = fl_m[a/4];
                else if (mode_m[0]) fl_m[a/4] = fl_m[a/4] & d;
                else er = 1'b1;
            end
            S_UC: begin
                if (a >= UCFG_WORDS * 4) er = 1'b1;
                else if (!we) rd = uc_m[a/4];
                else uc_m[a/4] = d;
            end
            default: er = 1'b1;
        endcase
    endfunction

    // Drive one access for one clock and compare the registered outputs.
    task automatic step(input string tag, input logic [1:0] sel, input logic we,
                        input logic [31:0] a, input logic [31:0] d);
        logic [31:0] e_rd;
        logic        e_er, e_bz;
        model(sel, we, a, d, e_rd, e_er, e_bz);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = we; bus_sel = sel;
        bus_addr = a[BUS_AW-1:0]; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        check(tag, "err_pulse", 32'(err_pulse), 32'(e_er));
        check(tag, "busy", 32'(busy), 32'(e_bz));
        check(tag, "bus_rvalid", 32'(bus_rvalid), 32'(!we));
        if (!we) check(tag, "bus_rdata", bus_rdata, e_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; bus_valid = 1'b0; bus_we = 1'b0; bus_sel = '0;
        bus_addr = '0; bus_wdata = '0;
        mode_m = '0;
        for (int i = 0; i < UCFG_WORDS; i++) uc_m[i] = '1;
        for (int i = 0; i < FW; i++) fl_m[i] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "err_pulse", 32'(err_pulse), 32'd0);
        check("R1", "busy", 32'(busy), 32'd0);
        step("R1", S_CTL, 1'b0, 32'h0, 0);
        step("R1", S_UC, 1'b0, 32'h0, 0);
        step("R1", S_UC, 1'b0, 32'hFC, 0);
        step("R3", S_CTL, 1'b0, 32'h4, 0);
        step("R2", S_CTL, 1'b1, 32'h0, 32'hFFFF_FFFF);
        step("R2", S_CTL, 1'b0, 32'h0, 0);
        step("R2", S_CTL, 1'b1, 32'h0, 32'hFFFF_FFF6);
        step("R2", S_CTL, 1'b0, 32'h0, 0);
        step("R9", S_CTL, 1'b1, 32'h10, KEY);
        step("R9", S_FL, 1'b0, 32'h0, 0);
        step("R9", S_FL, 1'b0, FLASH_BYTES - 4, 0);
        step("R5", S_FL, 1'b1, 32'h40, 32'h0);
        step("R5", S_FL, 1'b0, 32'h40, 0);
        step("R4", S_CTL, 1'b1, 32'h0, 32'h1);
        step("R4", S_FL, 1'b1, 32'h40, 32'hF0F0_FF00);
        step("R4", S_FL, 1'b1, 32'h40, 32'h0FFF_F0FF);
        step("R4", S_FL, 1'b0, 32'h40, 0);
        step("R4", S_FL, 1'b1, 32'h200, 32'h1234_5678);
        step("R4", S_FL, 1'b1, 32'h104, 32'h0);
        step("R8", S_CTL, 1'b1, 32'h8, 32'h200);
        step("R8", S_FL, 1'b0, 32'h200, 0);
        step("R6", S_CTL, 1'b1, 32'h0, 32'h3);
        step("R6", S_CTL, 1'b1, 32'h8, 32'h21C);
        step("R6", S_FL, 1'b0, 32'h200, 0);
        step("R6", S_FL, 1'b0, 32'h104, 0);
        step("R6", S_CTL, 1'b1, 32'hC, 32'h0FC);
        step("R6", S_FL, 1'b0, 32'h40, 0);
        step("R6", S_FL, 1'b0, 32'h104, 0);
        step("R7", S_FL, 1'b1, FLASH_BYTES - 8, 32'h0);
        step("R7", S_CTL, 1'b1, 32'h8, FLASH_BYTES);
        step("R7", S_CTL, 1'b1, 32'hC, 32'h8000_0000);
        step("R7", S_FL, 1'b0, FLASH_BYTES - 8, 0);
        step("R11", S_UC, 1'b1, 32'h10, 32'hDEAD_BEEF);
        step("R11", S_UC, 1'b1, 32'hFC, 32'h0000_0001);
        step("R11", S_UC, 1'b0, 32'h10, 0);
        step("R9", S_CTL, 1'b1, 32'h10, 32'h2);
        step("R9", S_UC, 1'b0, 32'h10, 0);
        step("R9", S_CTL, 1'b1, 32'h0, 32'h1);
        step("R9", S_CTL, 1'b1, 32'h10, KEY);
        step("R9", S_FL, 1'b0, FLASH_BYTES - 8, 0);
        step("R10", S_CTL, 1'b1, 32'h14, 32'h5);
        step("R10", S_UC, 1'b0, 32'hFC, 0);
        step("R10", S_CTL, 1'b1, 32'h0, 32'h0);
        step("R10", S_CTL, 1'b1, 32'h14, KEY);
        step("R10", S_UC, 1'b0, 32'h10, 0);
        step("R12", S_CTL, 1'b0, 32'h18, 0);
        step("R12", S_CTL, 1'b0, 32'h8, 0);
        step("R12", S_CTL, 1'b1, 32'h4, 32'h3);
        step("R12", S_CTL, 1'b1, 32'h40, 32'h3);
        step("R12", S_CTL, 1'b0, 32'h0, 0);
        step("R12", S_NO, 1'b0, 32'h0, 0);
        step("R12", S_NO, 1'b1, 32'h0, 32'h0);
        step("R13", S_FL, 1'b0, FLASH_BYTES, 0);
        step("R13", S_UC, 1'b1, UCFG_WORDS * 4, 32'h0);
        step("R13", S_UC, 1'b0, UCFG_WORDS * 4, 0);
        step("R14", S_UC, 1'b1, 32'h20, 32'h55AA_55AA);
        step("R14", S_UC, 1'b0, 32'h20, 0);

        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            logic [31:0] a, d;
            logic [1:0]  s;
            logic        w;
            r = $urandom_range(99);
            w = $urandom_range(1);
            d = $urandom();
            if (r < 15) begin
                s = S_CTL;
                a = 32'($urandom_range(8)) * 4;
                if (a == 32'h10 || a == 32'h14) begin
                    if ($urandom_range(3) == 0) d = KEY;
                    if (a == 32'h10 && $urandom_range(3) != 0) d = d | 32'h2;
                end
                if (a == 32'h8 || a == 32'hC)
                    d = 32'($urandom_range(FLASH_BYTES + 511));
            end else if (r < 70) begin
                s = S_FL;
                a = 32'($urandom_range(FW + 7)) * 4;
                if ($urandom_range(1) == 1) d = d | 32'hFFFF_0000;
            end else if (r < 97) begin
                s = S_UC;
                a = 32'($urandom_range(UCFG_WORDS + 3)) * 4;
            end else begin
                s = S_NO;
                a = 32'($urandom_range(15)) * 4;
            end
            step("RAND", s, w, a, d);
        end
        summary();
    end

endmodule